// File: doc/BRIEF.md
# Phase-Offset Programmable Clock Divider

This block divides a fast clock by an integer ratio set through two fields: one for the number of fast-clock cycles the output stays high, and one for the number of cycles it stays low. A synchronization input aligns the divider. While sync is held, the output parks at a chosen start level. When sync is released, the divider counts a programmable delay in whole fast-clock cycles before it produces its first edge.

The delay is a 5-bit value. Its lower four bits are a phase field, and the start-level bit acts as a fifth, most significant bit. This gives 32 delay states. Several dividers can share one clock and one sync pulse and use different phase settings. Their outputs are then skewed against each other in steps of one fast-clock period. The step pattern repeats with the divide ratio.

Settings are captured only while sync is asserted. A separate bypass setting, also captured at sync, passes the fast clock straight through. This is the divide-by-one case.

Top module: `phase_clk_div`

## Requirements
- R1: After reset and before any sync pulse, `div_o` is low and stays low.
- R2: From the first rising edge that samples `sync_i` high, and while it stays high, `div_o` equals `start_hi_i`.
- R3: Let D = 16*`start_hi_i` + `phase_i`, taken at the last sync edge (range 0 to 31). After sync is released, `div_o` makes its first transition on rising edge D+1, counting the first edge that samples `sync_i` low as edge 1.
- R4: Until that first transition, `div_o` keeps the start level. The first transition always goes to the opposite level.
- R5: After the first transition, `div_o` is high for `hi_cnt_i`+1 cycles and low for `lo_cnt_i`+1 cycles, repeating. Each field is 4 bits and encodes 1 to 16 cycles. With start level low, the high interval comes first.
- R6: Dividers that share clock, sync and ratio, with start bit low, have first rising edges that differ by (D_a - D_b) mod ratio cycles. An offset equal to the ratio matches an offset of zero.
- R7: Changing `hi_cnt_i`, `lo_cnt_i`, `phase_i` or `start_hi_i` without a sync pulse does not change the running `div_o` waveform.
- R8: When `bypass_i` is high at the last sync edge, `div_o` follows `clk`, and the phase and start settings have no effect on it.
- R9: The smallest ratio (1+1 cycles) and the largest (16+16 cycles) follow R3 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Active-high synchronization; holds and re-arms the divider |
| hi_cnt_i | input | CNT_W | High interval length minus one |
| lo_cnt_i | input | CNT_W | Low interval length minus one |
| phase_i | input | PHASE_W | Delay after sync, in fast-clock cycles (lower bits) |
| start_hi_i | input | 1 | Start level; also adds 2^PHASE_W cycles to the delay |
| bypass_i | input | 1 | Divide-by-one: output follows clk |
| div_o | output | 1 | Divided clock |

## Verification
Four dividers run from one sync pulse with different delays, and every output cycle is compared against a model of the waveform. A one-cycle slip in the delay counter would shift every edge of a lane. Reloading the wrong interval field would swap the duty cycle. Treating the start bit only as a level, and not as extra delay, would make the start-high lanes toggle 16 cycles early.

The bench also measures first-edge spacing modulo the ratio. It does this with an offset equal to the ratio, so an off-by-one wrap would be exposed. Mid-run changes to every setting check that the shadow registers do not leak. The bypass case checks that the output tracks both clock phases whatever the start bit says.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } pdiv_state_e;
endpackage

// File: rtl/pdiv_cfg_hold.sv
module pdiv_cfg_hold #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic [CNT_W-1:0] hi_cnt_i,
   input  logic [CNT_W-1:0] lo_cnt_i,
   input  logic             bypass_i,
   output logic [CNT_W-1:0] hi_s,
   output logic [CNT_W-1:0] lo_s,
   output logic             byp_s
);
   // Shadow copies follow the inputs only while sync is asserted.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_s  <= '0;
         lo_s  <= '0;
         byp_s <= 1'b0;
      end else if (sync_i) begin
         hi_s  <= hi_cnt_i;
         lo_s  <= lo_cnt_i;
         byp_s <= bypass_i;
      end
   end

   // R7: without sync the captured ratio and bypass cannot move
   p_shadow_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_i |=> ($stable(hi_s) && $stable(lo_s) && $stable(byp_s)));
endmodule

// File: rtl/pdiv_seq.sv
module pdiv_seq
   import pdiv_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter int PHASE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_i,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               start_hi_i,
   input  logic [CNT_W-1:0]   hi_s,
   input  logic [CNT_W-1:0]   lo_s,
   output logic               out_q
);
   localparam int DLY_W = PHASE_W + 1;
   localparam int CW    = (DLY_W > CNT_W) ? DLY_W : CNT_W;

   pdiv_state_e   st;
   logic [CW-1:0] cnt;
   logic [CW-1:0] reload;

   // Length of the interval about to begin, minus one.
   always_comb begin
      if (out_q) reload = CW'(lo_s);
      else       reload = CW'(hi_s);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         out_q <= 1'b0;
      end else if (sync_i) begin
         st    <= ST_WAIT;
         cnt   <= CW'({start_hi_i, phase_i});
         out_q <= start_hi_i;
      end else begin
         case (st)
            ST_WAIT, ST_RUN: begin
               if (cnt == '0) begin
                  out_q <= ~out_q;
                  cnt   <= reload;
                  st    <= ST_RUN;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               st <= st;
            end
         endcase
      end
   end

   // R1: no activity before the first sync
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !sync_i) |=> (out_q == $past(out_q)));
   // R2: sync parks the output at the start level
   p_sync_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (out_q == $past(start_hi_i)));
   // R4: no edge while the delay is still counting
   p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !sync_i && cnt != '0) |=> (out_q == $past(out_q)));
   // R3: the delay ends in an edge
   p_first_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !sync_i && cnt == '0) |=> (out_q != $past(out_q)));
   // R5: interval ends toggle the output
   p_run_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && !sync_i && cnt == '0) |=> (out_q != $past(out_q)));
endmodule

// File: rtl/pdiv_out.sv
module pdiv_out (
   input  logic clk,
   input  logic byp_s,
   input  logic out_q,
   output logic div_o
);
   // Divide-by-one passes the fast clock; otherwise the registered level.
   always_comb begin
      if (byp_s) div_o = clk;
      else       div_o = out_q;
   end
endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div #(
   parameter int CNT_W   = 4,
   parameter int PHASE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_i,
   input  logic [CNT_W-1:0]   hi_cnt_i,
   input  logic [CNT_W-1:0]   lo_cnt_i,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               start_hi_i,
   input  logic               bypass_i,
   output logic               div_o
);
   localparam int MAX_RATIO  = 2 * (1 << CNT_W);
   localparam int MAX_STATES = 1 << (PHASE_W + 1);

   generate
      if (CNT_W < 1 || CNT_W > 12) begin : g_bad_cnt_w
         $error("phase_clk_div: CNT_W out of range");
      end
      if (PHASE_W < 1 || PHASE_W > 12) begin : g_bad_phase_w
         $error("phase_clk_div: PHASE_W out of range");
      end
      if (MAX_RATIO < 4 || MAX_STATES < 4) begin : g_bad_derived
         $error("phase_clk_div: derived sizes too small");
      end
   endgenerate

   logic [CNT_W-1:0] hi_s;
   logic [CNT_W-1:0] lo_s;
   logic             byp_s;
   logic             out_q;

   pdiv_cfg_hold #(.CNT_W(CNT_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (sync_i),
      .hi_cnt_i (hi_cnt_i),
      .lo_cnt_i (lo_cnt_i),
      .bypass_i (bypass_i),
      .hi_s     (hi_s),
      .lo_s     (lo_s),
      .byp_s    (byp_s)
   );

   pdiv_seq #(.CNT_W(CNT_W), .PHASE_W(PHASE_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_i     (sync_i),
      .phase_i    (phase_i),
      .start_hi_i (start_hi_i),
      .hi_s       (hi_s),
      .lo_s       (lo_s),
      .out_q      (out_q)
   );

   pdiv_out u_out (
      .clk   (clk),
      .byp_s (byp_s),
      .out_q (out_q),
      .div_o (div_o)
   );
endmodule

// File: tb/phase_clk_div_test.sv
`timescale 1ns/1ps
module phase_clk_div_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync = 1'b0;
   logic [3:0] hi = '0;
   logic [3:0] lo = '0;
   logic       byp = 1'b0;
   logic [3:0] ph [4];
   logic       stv [4];
   logic       dout [4];

   int checks = 0;
   int fails = 0;
   bit mon_en = 1'b0;
   int mon_n = 0;
   int rise_n [4];
   logic prv [4];
   logic [3:0] exp_q [$];

   always #5 clk = ~clk;

   phase_clk_div uut (.clk(clk), .rst_n(rst_n), .sync_i(sync), .hi_cnt_i(hi), .lo_cnt_i(lo),
      .phase_i(ph[0]), .start_hi_i(stv[0]), .bypass_i(byp), .div_o(dout[0]));
   phase_clk_div uut_l1 (.clk(clk), .rst_n(rst_n), .sync_i(sync), .hi_cnt_i(hi), .lo_cnt_i(lo),
      .phase_i(ph[1]), .start_hi_i(stv[1]), .bypass_i(byp), .div_o(dout[1]));
   phase_clk_div uut_l2 (.clk(clk), .rst_n(rst_n), .sync_i(sync), .hi_cnt_i(hi), .lo_cnt_i(lo),
      .phase_i(ph[2]), .start_hi_i(stv[2]), .bypass_i(byp), .div_o(dout[2]));
   phase_clk_div uut_l3 (.clk(clk), .rst_n(rst_n), .sync_i(sync), .hi_cnt_i(hi), .lo_cnt_i(lo),
      .phase_i(ph[3]), .start_hi_i(stv[3]), .bypass_i(byp), .div_o(dout[3]));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Expected level after rising edge n (n=1 first edge with sync low).
   function automatic bit exp_lvl(int n, int s, int d, int hc, int lc);
      int m;
      if (n <= d) return s[0];
      m = (n - d - 1) % (hc + lc);
      if (s == 0) return (m < hc);
      return !(m < lc);
   endfunction

   function automatic int modp(int x, int r);
      return ((x % r) + r) % r;
   endfunction

   // Monitor: pops one expected vector per cycle and compares all lanes.
   always @(negedge clk) begin
      if (mon_en && exp_q.size() != 0) begin
         logic [3:0] e;
         e = exp_q.pop_front();
         mon_n++;
         for (int i = 0; i < 4; i++) begin
            chk(dout[i] === e[i], "R3 R4 R5 lane waveform", int'(dout[i]), int'(e[i]));
            if (dout[i] === 1'b1 && prv[i] === 1'b0 && rise_n[i] < 0) rise_n[i] = mon_n;
            prv[i] = dout[i];
         end
      end
   end

   // Driver: arms the dividers, pushes the expected waveform, releases sync.
   task automatic run_case(input int hf, input int lf, input int ncyc, input bit disturb,
                           input string tag);
      int sd [4];
      int ss [4];
      int r;
      @(negedge clk);
      hi = hf[3:0]; lo = lf[3:0]; byp = 1'b0; sync = 1'b1;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         chk(dout[i] === stv[i], "R2 sync holds start level", int'(dout[i]), int'(stv[i]));
         ss[i] = int'(stv[i]);
         sd[i] = 16 * ss[i] + int'(ph[i]);
         rise_n[i] = -1;
         prv[i] = stv[i];
      end
      r = hf + lf + 2;
      for (int n = 1; n <= ncyc; n++) begin
         logic [3:0] e;
         for (int i = 0; i < 4; i++) e[i] = exp_lvl(n, ss[i], sd[i], hf + 1, lf + 1);
         exp_q.push_back(e);
      end
      mon_n = 0;
      sync = 1'b0;
      @(posedge clk);
      mon_en = 1'b1;
      if (disturb) begin
         // R7: move every setting mid-run without a sync
         repeat (12) @(negedge clk);
         hi = ~hi; lo = lo + 4'd5; byp = 1'b1;
         for (int i = 0; i < 4; i++) begin
            ph[i] = ph[i] + 4'd3;
            stv[i] = ~stv[i];
         end
      end
      while (exp_q.size() != 0) @(negedge clk);
      @(posedge clk);
      mon_en = 1'b0;
      byp = 1'b0;
      // R6: first rising-edge spacing modulo the ratio
      for (int i = 1; i < 4; i++) begin
         if (ss[0] == 0 && ss[i] == 0) begin
            chk(rise_n[i] > 0 && rise_n[0] > 0 &&
                modp(rise_n[i] - rise_n[0], r) == modp(sd[i] - sd[0], r),
                "R6 edge spacing", modp(rise_n[i] - rise_n[0], r), modp(sd[i] - sd[0], r));
         end
      end
      $display("case %s done", tag);
   endtask

   task automatic set_lanes(input int p0, input int p1, input int p2, input int p3,
                            input int s0, input int s1, input int s2, input int s3);
      ph[0] = p0[3:0]; ph[1] = p1[3:0]; ph[2] = p2[3:0]; ph[3] = p3[3:0];
      stv[0] = s0[0]; stv[1] = s1[0]; stv[2] = s2[0]; stv[3] = s3[0];
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      set_lanes(3, 5, 7, 9, 1, 1, 0, 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle and low before any sync, despite non-zero settings
      repeat (6) begin
         @(negedge clk);
         for (int i = 0; i < 4; i++) chk(dout[i] === 1'b0, "R1 idle low", int'(dout[i]), 0);
      end
      // R6: divide by 4, offsets 0/1/2 and 4 (same as 0)
      set_lanes(0, 1, 2, 4, 0, 0, 0, 0);
      run_case(1, 1, 40, 1'b0, "div4");
      // R5 R6: divide by 7, uneven duty, offset 13 wraps
      set_lanes(0, 3, 6, 13, 0, 0, 0, 0);
      run_case(2, 3, 56, 1'b0, "div7");
      // R3 R4: start-high lanes add 16 cycles of delay
      set_lanes(0, 0, 15, 15, 0, 1, 1, 0);
      run_case(1, 1, 60, 1'b0, "start");
      // R7: settings change mid-run, waveform must not
      set_lanes(0, 2, 4, 7, 0, 0, 0, 0);
      run_case(3, 3, 50, 1'b1, "frozen");
      // R9: largest ratio 32 and smallest ratio 2
      set_lanes(0, 1, 15, 8, 0, 0, 0, 1);
      run_case(15, 15, 100, 1'b0, "max");
      set_lanes(0, 1, 2, 3, 0, 0, 0, 0);
      run_case(0, 0, 20, 1'b0, "min");
      // R8: bypass follows clk, start and phase ignored
      set_lanes(5, 9, 0, 15, 1, 0, 1, 1);
      @(negedge clk);
      byp = 1'b1; sync = 1'b1;
      repeat (2) @(negedge clk);
      sync = 1'b0;
      repeat (6) begin
         @(posedge clk); #2;
         for (int i = 0; i < 4; i++) chk(dout[i] === 1'b1, "R8 bypass high phase", int'(dout[i]), 1);
         @(negedge clk); #2;
         for (int i = 0; i < 4; i++) chk(dout[i] === 1'b0, "R8 bypass low phase", int'(dout[i]), 0);
      end
      // R8: leaving bypass needs a sync and restores division
      set_lanes(0, 1, 2, 3, 0, 0, 0, 0);
      run_case(1, 2, 30, 1'b0, "after_bypass");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule